// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is a target device on a two-wire serial bus with a clock line and an open-drain data line. It holds 256 bytes in an on-chip register array. A bus controller selects it with an address byte and can then either load a word pointer and write a byte, or read bytes out one after another starting at the pointer.

Both bus lines pass through two-flop synchronizers into the system clock domain. The block never drives SDA high. It only requests that SDA be pulled low. The surrounding pad logic combines that request with the bus wire.

A completed write is stored in the array when the STOP condition arrives. The block then spends a fixed number of system clocks in a programming interval, which stands in for a non-volatile write. During that interval it answers nothing on the bus.

Top module: `twowire_mem_target`

## Requirements
- R1: After reset the data pull request is low and every array location reads back as 0x00.
- R2: After a START, the block acknowledges an address byte whose bits 7..4 equal 1010 and whose bits 3..1 equal the SUB_ADDR parameter (default 000). The acknowledge is SDA held low for the whole ninth SCL clock. Bit 0 is the direction: 0 is write and 1 is read. With the defaults, 0xA0 selects a write and 0xA1 selects a read.
- R3: In a write, the first byte after the address loads the word pointer. Every byte received in a write is acknowledged on its ninth clock.
- R4: Each data byte sets the pending write to (pointer, byte) and then increments the pointer, wrapping from 255 to 0. If several data bytes arrive, the last one wins. A STOP with a write pending stores that byte in the array.
- R5: After that STOP, for PROG_CYCLES system clocks, the block never pulls SDA low. It ignores START, address bytes and STOP in that time. Once the interval ends, it answers normally again.
- R6: In a read, bytes are sent MSB first from the pointer location. A new bit is placed on SDA after each SCL falling edge. The pointer increments after each byte and wraps from 255 to 0.
- R7: If the controller pulls SDA low on the ninth clock of a read byte, the next byte follows. If SDA is left high, the block releases SDA and stays silent until the next START.
- R8: If the address byte does not match, the block leaves SDA released for every later clock until the next START.
- R9: A repeated START during a transfer restarts address matching and discards any pending write. The array is unchanged and no programming interval follows.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both as seen after the synchronizers. A STOP without a pending write returns the block to idle with no lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_pull_o | output | 1 | 1 requests that SDA be pulled low |

## Verification
The hardest state to reach from the ports is the lockout after a write. The bench sends a fresh START and address byte right after the write's STOP, inside the programming interval, and checks that no clock of it sees a pull request. It then waits for the interval to end and reads the stored byte back.

The second difficult case is a write discarded by a repeated START. The bench loads a data byte, restarts into a read, and then addresses the block again at once. This shows both that no lockout began and that the location still holds its old value.

Pointer wrap-around is reached by writing the last two locations and reading sequentially across the boundary.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE,
        ST_PROG
    } tw_state_e;

    localparam int unsigned TW_BYTE_BITS = 8;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_s;

    prev_s prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    // Line changes are qualified by SCL being high before and after the edge.
    assign start_o    = prev_q.scl && scl_s && prev_q.sda && !sda_s;
    assign stop_o     = prev_q.scl && scl_s && !prev_q.sda && sda_s;
    assign scl_rise_o = !prev_q.scl && scl_s;
    assign scl_fall_o = prev_q.scl && !scl_s;

    a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

endmodule

// File: rtl/tw_byte_array.sv
module tw_byte_array #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/tw_target_ctrl.sv
module tw_target_ctrl
    import tw_pkg::*;
#(
    parameter int unsigned AW          = 8,
    parameter logic [3:0]  DEV_CODE    = 4'b1010,
    parameter logic [2:0]  SUB_ADDR    = 3'b000,
    parameter int unsigned PROG_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl_i,
    input  logic          sda_lvl_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic [7:0]    rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          pull_o
);

    localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
    localparam logic [3:0]  LAST_BIT = 4'(TW_BYTE_BITS);

    typedef struct packed {
        tw_state_e     st;
        logic [7:0]    sr;
        logic [3:0]    cnt;
        logic [AW-1:0] ptr;
        logic [7:0]    tx;
        logic          rw;
        logic          mack;
        logic          wpend;
        logic [AW-1:0] waddr;
        logic [7:0]    wdata;
        logic [CW-1:0] pcnt;
        logic          pull;
    } ctrl_s;

    ctrl_s q, d;
    logic  we_d;
    logic  addr_hit;

    assign addr_hit = (q.sr[7:4] == DEV_CODE) && (q.sr[3:1] == SUB_ADDR);

    always_comb begin
        d    = q;
        we_d = 1'b0;
        if (q.st == ST_PROG) begin
            d.pull = 1'b0;
            if (q.pcnt == '0) d.st = ST_IDLE;
            else              d.pcnt = q.pcnt - 1'b1;
        end else if (start_i) begin
            d.st    = ST_DEV;
            d.cnt   = '0;
            d.pull  = 1'b0;
            d.wpend = 1'b0;
        end else if (stop_i) begin
            d.pull = 1'b0;
            if (q.wpend) begin
                we_d    = 1'b1;
                d.wpend = 1'b0;
                d.st    = ST_PROG;
                d.pcnt  = CW'(PROG_CYCLES - 1);
            end else begin
                d.st = ST_IDLE;
            end
        end else begin
            unique case (q.st)
                ST_DEV, ST_WORD, ST_DATA: begin
                    if (scl_rise_i && q.cnt < LAST_BIT) begin
                        d.sr  = {q.sr[6:0], sda_lvl_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == LAST_BIT) begin
                        d.cnt  = '0;
                        d.pull = 1'b1;
                        if (q.st == ST_DEV) begin
                            if (addr_hit) begin
                                d.st = ST_DEV_ACK;
                                d.rw = q.sr[0];
                            end else begin
                                d.st   = ST_IGNORE;
                                d.pull = 1'b0;
                            end
                        end else if (q.st == ST_WORD) begin
                            d.ptr = q.sr[AW-1:0];
                            d.st  = ST_WORD_ACK;
                        end else begin
                            d.waddr = q.ptr;
                            d.wdata = q.sr;
                            d.wpend = 1'b1;
                            d.ptr   = q.ptr + 1'b1;
                            d.st    = ST_DATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall_i) begin
                        if (q.rw) begin
                            d.st   = ST_TX;
                            d.tx   = rdata_i;
                            d.pull = ~rdata_i[7];
                            d.cnt  = 4'd1;
                        end else begin
                            d.st   = ST_WORD;
                            d.pull = 1'b0;
                            d.cnt  = '0;
                        end
                    end
                end
                ST_WORD_ACK, ST_DATA_ACK: begin
                    if (scl_fall_i) begin
                        d.st   = ST_DATA;
                        d.pull = 1'b0;
                        d.cnt  = '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.cnt == LAST_BIT) begin
                            d.st   = ST_TX_ACK;
                            d.pull = 1'b0;
                            d.ptr  = q.ptr + 1'b1;
                        end else begin
                            d.pull = ~q.tx[3'd7 - q.cnt[2:0]];
                            d.cnt  = q.cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.st   = ST_TX;
                            d.tx   = rdata_i;
                            d.pull = ~rdata_i[7];
                            d.cnt  = 4'd1;
                        end else begin
                            d.st   = ST_IGNORE;
                            d.pull = 1'b0;
                        end
                    end
                end
                default: d.pull = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raddr_o = q.ptr;
    assign we_o    = we_d;
    assign waddr_o = q.waddr;
    assign wdata_o = q.wdata;
    assign pull_o  = q.pull;

    // R5: silent for the whole programming interval
    a_r5_prog_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG) |-> !pull_o);

    // R5: interval counter only moves down while programming
    a_r5_prog_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG && $past(q.st == ST_PROG)) |-> (q.pcnt < $past(q.pcnt)));

    // R4: an array write is always followed by the programming interval
    a_r4_store_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> (q.st == ST_PROG));

    // R4: a store happens only on a bus STOP
    a_r4_store_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> stop_i);

    // R8: no pull request after a mismatch or a read NACK
    a_r8_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !pull_o);

    // R6: a new pull request only appears while SCL is low
    a_r6_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_o) |-> !scl_lvl_i);

endmodule

// File: rtl/twowire_mem_target.sv
module twowire_mem_target #(
    parameter logic [2:0]  SUB_ADDR    = 3'b000,
    parameter int unsigned PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    localparam int unsigned AW = 8;
    localparam int unsigned DW = tw_pkg::TW_BYTE_BITS;

    logic [1:0]    line_s;
    logic          start_w, stop_w, rise_w, fall_w;
    logic          we_w;
    logic [AW-1:0] waddr_w, raddr_w;
    logic [DW-1:0] wdata_w, rdata_w;

    tw_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s)
    );

    tw_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (line_s[1]),
        .sda_s      (line_s[0]),
        .start_o    (start_w),
        .stop_o     (stop_w),
        .scl_rise_o (rise_w),
        .scl_fall_o (fall_w)
    );

    tw_byte_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (wdata_w),
        .raddr_i (raddr_w),
        .rdata_o (rdata_w)
    );

    tw_target_ctrl #(
        .AW          (AW),
        .DEV_CODE    (4'b1010),
        .SUB_ADDR    (SUB_ADDR),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (line_s[1]),
        .sda_lvl_i  (line_s[0]),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .scl_rise_i (rise_w),
        .scl_fall_i (fall_w),
        .rdata_i    (rdata_w),
        .raddr_o    (raddr_w),
        .we_o       (we_w),
        .waddr_o    (waddr_w),
        .wdata_o    (wdata_w),
        .pull_o     (sda_pull_o)
    );

endmodule

// File: tb/tb_twowire_mem_target.sv
module tb_twowire_mem_target;

    localparam int PROG = 1000;
    localparam int H    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_o;
    logic bus_sda;

    always #5 clk = ~clk;

    assign bus_sda = sda_m & ~sda_pull_o;

    twowire_mem_target #(.SUB_ADDR(3'b000), .PROG_CYCLES(PROG)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (bus_sda),
        .sda_pull_o (sda_pull_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    logic  exp_pull = 1'b0;
    string cur_req = "R1";

    logic [7:0] mem_m [256];
    logic [7:0] ptr_m = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Clock-by-clock comparison of the pull request against the model while SCL is high.
    always @(negedge clk) begin
        if (cmp_on && scl_m && !done) chk(sda_pull_o === exp_pull, cur_req, sda_pull_o, exp_pull);
    end

    task automatic bus_start();
        exp_pull = 1'b0;
        if (!scl_m) begin
            sda_m = 1'b1;
            repeat (H) @(negedge clk);
            scl_m = 1'b1;
        end
        sda_m = 1'b1;
        repeat (H) @(negedge clk);
        sda_m = 1'b0;
        repeat (H) @(negedge clk);
        scl_m = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_stop();
        exp_pull = 1'b0;
        sda_m = 1'b0;
        repeat (H) @(negedge clk);
        scl_m = 1'b1;
        repeat (H) @(negedge clk);
        sda_m = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic clk_bit(input logic msda, input logic exp, output logic seen);
        sda_m = msda;
        exp_pull = exp;
        repeat (H) @(negedge clk);
        scl_m = 1'b1;
        repeat (H/2) @(negedge clk);
        seen = bus_sda;
        repeat (H/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic seen;
        cur_req = req;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, seen);
        clk_bit(1'b1, exp_ack, seen);
        chk(seen === ~exp_ack, req, seen, ~exp_ack);
    endtask

    task automatic recv_byte(input logic mack, input string req);
        logic [7:0] got;
        logic [7:0] exp;
        logic       seen;
        exp = mem_m[ptr_m];
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, ~exp[i], seen);
            got[i] = seen;
        end
        clk_bit(~mack, 1'b0, seen);
        ptr_m = ptr_m + 8'd1;
        chk(got === exp, req, got, exp);
    endtask

    task automatic write_one(input logic [7:0] wa, input logic [7:0] wd);
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(wa, 1'b1, "R3");
        ptr_m = wa;
        send_byte(wd, 1'b1, "R3");
        mem_m[ptr_m] = wd;
        ptr_m = ptr_m + 8'd1;
        bus_stop();
    endtask

    task automatic wait_prog();
        repeat (PROG + 40) @(negedge clk);
    endtask

    task automatic set_ptr_and_read(input logic [7:0] wa);
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(wa, 1'b1, "R3");
        ptr_m = wa;
        bus_start();
        send_byte(8'hA1, 1'b1, "R9");
    endtask

    initial begin
        logic seen;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(sda_pull_o === 1'b0, "R1", sda_pull_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_pull_o === 1'b0, "R1", sda_pull_o, 0);
        cmp_on = 1'b1;

        // R3/R4: byte write, then R5: addressed inside the programming interval
        write_one(8'h10, 8'hA5);
        bus_start();
        send_byte(8'hA1, 1'b0, "R5");
        send_byte(8'hA0, 1'b0, "R5");
        bus_stop();
        wait_prog();

        // R6/R7/R9: random read of the stored byte, NACK, then extra clocks stay silent
        set_ptr_and_read(8'h10);
        recv_byte(1'b0, "R6");
        cur_req = "R7";
        for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, seen);
        bus_stop();

        // R10: a read STOP leaves no lockout; current-address read of unwritten cell (R1)
        bus_start();
        send_byte(8'hA1, 1'b1, "R10");
        recv_byte(1'b0, "R1");
        bus_stop();

        // R4/R6: wrap of pointer across the array end
        write_one(8'hFF, 8'h77);
        wait_prog();
        write_one(8'h00, 8'h5A);
        wait_prog();
        set_ptr_and_read(8'hFE);
        recv_byte(1'b1, "R7");
        recv_byte(1'b1, "R6");
        recv_byte(1'b1, "R6");
        recv_byte(1'b0, "R7");
        bus_stop();

        // R4: two data bytes, last one wins at the advanced pointer
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h20, 1'b1, "R3");
        send_byte(8'h11, 1'b1, "R3");
        send_byte(8'h22, 1'b1, "R3");
        mem_m[8'h21] = 8'h22;
        bus_stop();
        wait_prog();
        set_ptr_and_read(8'h20);
        recv_byte(1'b1, "R4");
        recv_byte(1'b0, "R4");
        bus_stop();

        // R9: repeated START discards a pending write and starts no lockout
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h30, 1'b1, "R3");
        ptr_m = 8'h30;
        send_byte(8'h99, 1'b1, "R3");
        ptr_m = 8'h31;
        bus_start();
        send_byte(8'hA1, 1'b1, "R9");
        recv_byte(1'b0, "R9");
        bus_stop();
        set_ptr_and_read(8'h30);
        recv_byte(1'b0, "R9");
        bus_stop();

        // R8: wrong device code, then wrong sub-address
        bus_start();
        send_byte(8'hB0, 1'b0, "R8");
        send_byte(8'h00, 1'b0, "R8");
        bus_stop();
        bus_start();
        send_byte(8'hA2, 1'b0, "R8");
        send_byte(8'h10, 1'b0, "R8");
        bus_stop();

        // R2: still selectable afterwards; pointer kept from before
        bus_start();
        send_byte(8'hA1, 1'b1, "R2");
        recv_byte(1'b0, "R2");
        bus_stop();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule